// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, once per received frame, whether the frame is kept and which of eight receive channels gets it. It looks at the parsed destination address, the length/type word, the tag control word, the byte count and a single error flag. It sorts the frame into a class: proper, undersized, oversized, pause, VLAN-tagged or errored. It then settles the address decision in this order: broadcast first, then group addresses through a 64-entry hash table, then a small table of individual addresses. When none of these match and promiscuous reception is on, the frame goes to the promiscuous channel. Otherwise it is dropped and flagged as filtered.

All configuration values are plain inputs held by the surrounding register file. The one exception is the maximum frame length, which this block holds in its own register with a load strobe. The decision is registered: `out_valid` and the result fields appear on the clock edge after `hdr_valid`.

Top module: `rxf_filter`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `hdr_valid` high, and low otherwise. When `out_valid` is low, `accept`, `filtered`, `chan`, `fclass` and `vlan_prio` are all 0.
- R2: Group addresses are those with `dest_addr[0]`=1 (bit 0 of the first byte on the wire) that are not all ones. Each bit i of the 6-bit hash index is the XOR of address bits i, i+6, i+12, and so on up to bit 47. The index selects bit `{hash_hi,hash_lo}[index]`. A group frame matches when `mcast_en`=1 and that bit is 1, and it is then steered to `mcast_chan`.
- R3: An all-ones address with `bcast_en`=1 goes to `bcast_chan`. With `bcast_en`=0 it never uses the hash table and counts as unmatched.
- R4: An individual address matches table entry k when `ucast_valid[k]`=1, the stored address is equal, and `ucast_chan_en` has the bit of that entry's channel set. Entry k occupies bits `[48k+47:48k]` of `ucast_addr` and bits `[3k+2:3k]` of `ucast_chan`. When several entries qualify, the lowest index wins.
- R5: An unmatched frame goes to `promisc_chan` when `promisc_en`=1. Otherwise it is dropped with `filtered`=1. When `accept`=0, `chan` is 0.
- R6: The class code is 0 proper, 1 undersized (byte count below 64), 2 oversized (byte count above the maximum length), 3 pause, 4 VLAN or 5 errored. Counts of 64 and of the maximum itself are in range. Only classes 0 and 4 can be accepted.
- R7: The maximum length resets to 1518. A cycle with `max_len_wr`=1 loads `max_len_wdata`, and that value takes effect from the next cycle.
- R8: A length/type of 0x8808 gives class 3 (pause), and the frame is not accepted.
- R9: A length/type of 0x8100 gives class 4 (VLAN). `vlan_prio` then carries `vlan_tci[15:13]`; for every other class it is 0.
- R10: `frame_err`=1 gives class 5, which takes precedence over every other class, and the frame is not accepted.
- R11: While reset is asserted and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header fields valid for one frame this cycle |
| dest_addr | input | 48 | Destination address, first byte on the wire in [7:0] |
| len_type | input | 16 | Length/type word |
| vlan_tci | input | 16 | Tag control word following a VLAN type |
| byte_count | input | 16 | Frame length in bytes |
| frame_err | input | 1 | Code, alignment or CRC error seen |
| ucast_addr | input | 192 | Individual address table, 48 bits per entry |
| ucast_chan | input | 12 | Channel per table entry, 3 bits each |
| ucast_valid | input | 4 | Entry valid bits |
| ucast_chan_en | input | 8 | Per-channel individual-address reception enable |
| hash_lo | input | 32 | Hash table bits 31:0 |
| hash_hi | input | 32 | Hash table bits 63:32 |
| mcast_en | input | 1 | Group reception enable |
| mcast_chan | input | 3 | Channel for group frames |
| bcast_en | input | 1 | Broadcast reception enable |
| bcast_chan | input | 3 | Channel for broadcast frames |
| promisc_en | input | 1 | Accept unmatched frames |
| promisc_chan | input | 3 | Channel for unmatched frames |
| max_len_wr | input | 1 | Load strobe for the maximum length |
| max_len_wdata | input | 16 | New maximum length |
| out_valid | output | 1 | Decision valid |
| accept | output | 1 | Frame is kept |
| chan | output | 3 | Receive channel when accepted |
| fclass | output | 3 | Frame class code |
| vlan_prio | output | 3 | Tag priority for VLAN frames |
| filtered | output | 1 | Dropped for lack of an address match |

## Verification
Directed frames cover four cases:
- Individual addresses that hit one entry, two entries with the same address, and a disabled channel. These separate the lowest-index rule from a plain equality test.
- Group addresses with the selected hash bit clear and then set, and an all-ones address with broadcast off while the hash table is full. These show that the fold index is right and that broadcast bypasses the table.
- Byte counts of 63, 64, the maximum and the maximum plus one, both at the reset maximum and after a load. These pin down both ends of the size range.
- Pause, VLAN and errored frames. These confirm the class precedence.

A few hundred random frames with mixed addresses, sizes, types and promiscuous settings are then compared every clock against a behavioural model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [2:0] {
      FC_PROPER = 3'd0,
      FC_UNDER  = 3'd1,
      FC_OVER   = 3'd2,
      FC_PAUSE  = 3'd3,
      FC_VLAN   = 3'd4,
      FC_ERROR  = 3'd5
   } fclass_e;

   localparam logic [15:0] ETYPE_VLAN  = 16'h8100;
   localparam logic [15:0] ETYPE_PAUSE = 16'h8808;
endpackage

// File: rtl/rxf_hash.sv
module rxf_hash #(
   parameter int ADDR_W = 48,
   parameter int HASH_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [HASH_W-1:0] idx
);
   localparam int TAPS = ADDR_W / HASH_W;

   if (ADDR_W % HASH_W != 0) begin : g_bad_width
      $error("rxf_hash: ADDR_W must be a multiple of HASH_W");
   end

   for (genvar i = 0; i < HASH_W; i++) begin : g_bit
      logic [TAPS-1:0] taps;
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         assign taps[k] = addr[i + k*HASH_W];
      end
      assign idx[i] = ^taps;
   end
endmodule

// File: rtl/rxf_size_class.sv
module rxf_size_class
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input  logic [LEN_W-1:0] byte_count,
   input  logic [LEN_W-1:0] max_len,
   input  logic [15:0]      len_type,
   input  logic             frame_err,
   output fclass_e          cls
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

   if (MIN_LEN >= (1 << LEN_W)) begin : g_bad_min
      $error("rxf_size_class: MIN_LEN does not fit in LEN_W");
   end

   always_comb begin
      if (frame_err)                  cls = FC_ERROR;
      else if (byte_count < MIN_L)    cls = FC_UNDER;
      else if (byte_count > max_len)  cls = FC_OVER;
      else if (len_type == ETYPE_PAUSE) cls = FC_PAUSE;
      else if (len_type == ETYPE_VLAN)  cls = FC_VLAN;
      else                            cls = FC_PROPER;
   end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
   parameter int NUM    = 4,
   parameter int ADDR_W = 48,
   parameter int CHAN_W = 3
) (
   input  logic [ADDR_W-1:0]     da,
   input  logic [NUM*ADDR_W-1:0] tab_addr,
   input  logic [NUM*CHAN_W-1:0] tab_chan,
   input  logic [NUM-1:0]        tab_valid,
   input  logic [(1<<CHAN_W)-1:0] chan_en,
   output logic                  hit,
   output logic [CHAN_W-1:0]     hit_chan
);
   if (NUM < 1) begin : g_bad_num
      $error("rxf_addr_match: NUM must be at least 1");
   end

   logic [NUM-1:0]    cand;
   logic [CHAN_W-1:0] ech [NUM];

   for (genvar k = 0; k < NUM; k++) begin : g_entry
      assign ech[k]  = tab_chan[k*CHAN_W +: CHAN_W];
      assign cand[k] = tab_valid[k] && (tab_addr[k*ADDR_W +: ADDR_W] == da)
                       && chan_en[ech[k]];
   end

   always_comb begin
      hit      = |cand;
      hit_chan = '0;
      for (int k = NUM-1; k >= 0; k--) begin
         if (cand[k]) hit_chan = ech[k];
      end
   end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
   import rxf_pkg::*;
#(
   parameter int NUM_UCAST   = 4,
   parameter int ADDR_W      = 48,
   parameter int CHAN_W      = 3,
   parameter int HASH_W      = 6,
   parameter int LEN_W       = 16,
   parameter int MIN_LEN     = 64,
   parameter int MAX_LEN_RST = 1518,
   localparam int NUM_CHAN   = 1 << CHAN_W,
   localparam int TBL_W      = 1 << HASH_W,
   localparam int HALF_W     = TBL_W / 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hdr_valid,
   input  logic [ADDR_W-1:0]           dest_addr,
   input  logic [15:0]                 len_type,
   input  logic [15:0]                 vlan_tci,
   input  logic [LEN_W-1:0]            byte_count,
   input  logic                        frame_err,
   input  logic [NUM_UCAST*ADDR_W-1:0] ucast_addr,
   input  logic [NUM_UCAST*CHAN_W-1:0] ucast_chan,
   input  logic [NUM_UCAST-1:0]        ucast_valid,
   input  logic [NUM_CHAN-1:0]         ucast_chan_en,
   input  logic [HALF_W-1:0]           hash_lo,
   input  logic [HALF_W-1:0]           hash_hi,
   input  logic                        mcast_en,
   input  logic [CHAN_W-1:0]           mcast_chan,
   input  logic                        bcast_en,
   input  logic [CHAN_W-1:0]           bcast_chan,
   input  logic                        promisc_en,
   input  logic [CHAN_W-1:0]           promisc_chan,
   input  logic                        max_len_wr,
   input  logic [LEN_W-1:0]            max_len_wdata,
   output logic                        out_valid,
   output logic                        accept,
   output logic [CHAN_W-1:0]           chan,
   output logic [2:0]                  fclass,
   output logic [2:0]                  vlan_prio,
   output logic                        filtered
);
   if (MAX_LEN_RST >= (1 << LEN_W) || MAX_LEN_RST < MIN_LEN) begin : g_bad_max
      $error("rxf_filter: MAX_LEN_RST out of range");
   end

   logic [LEN_W-1:0]  max_len_q;
   logic [HASH_W-1:0] hidx;
   logic [TBL_W-1:0]  tbl;
   logic              uc_hit;
   logic [CHAN_W-1:0] uc_chan;
   fclass_e           cls;
   logic              addr_ok, class_ok, acc_d;
   logic [CHAN_W-1:0] dch;

   always_ff @(posedge clk) begin
      if (!rst_n)          max_len_q <= LEN_W'(MAX_LEN_RST);
      else if (max_len_wr) max_len_q <= max_len_wdata;
   end

   rxf_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
      .addr(dest_addr), .idx(hidx));

   rxf_addr_match #(.NUM(NUM_UCAST), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_match (
      .da(dest_addr), .tab_addr(ucast_addr), .tab_chan(ucast_chan),
      .tab_valid(ucast_valid), .chan_en(ucast_chan_en),
      .hit(uc_hit), .hit_chan(uc_chan));

   rxf_size_class #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_size (
      .byte_count(byte_count), .max_len(max_len_q), .len_type(len_type),
      .frame_err(frame_err), .cls(cls));

   assign tbl = {hash_hi, hash_lo};

   always_comb begin
      addr_ok = 1'b0;
      dch     = '0;
      if (&dest_addr) begin
         if (bcast_en) begin addr_ok = 1'b1; dch = bcast_chan; end
      end else if (dest_addr[0]) begin
         if (mcast_en && tbl[hidx]) begin addr_ok = 1'b1; dch = mcast_chan; end
      end else if (uc_hit) begin
         addr_ok = 1'b1;
         dch     = uc_chan;
      end
      if (!addr_ok && promisc_en) begin
         addr_ok = 1'b1;
         dch     = promisc_chan;
      end
      class_ok = (cls == FC_PROPER) || (cls == FC_VLAN);
      acc_d    = hdr_valid && addr_ok && class_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         accept    <= 1'b0;
         chan      <= '0;
         fclass    <= FC_PROPER;
         vlan_prio <= '0;
         filtered  <= 1'b0;
      end else begin
         out_valid <= hdr_valid;
         accept    <= acc_d;
         chan      <= acc_d ? dch : '0;
         fclass    <= hdr_valid ? cls : FC_PROPER;
         vlan_prio <= (hdr_valid && cls == FC_VLAN) ? vlan_tci[15:13] : 3'd0;
         filtered  <= hdr_valid && !addr_ok;
      end
   end

   // Assertions
   assert_out_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> out_valid);
   assert_out_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> (!out_valid && !accept && !filtered));
   assert_filtered_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      filtered |-> (out_valid && !accept));
   assert_chan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |-> (chan == '0));
   assert_under_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fclass == FC_UNDER) |-> !accept);
   assert_maxlen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !max_len_wr |=> $stable(max_len_q));
   assert_pause_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fclass == FC_PAUSE) |-> !accept);
   assert_prio_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fclass != FC_VLAN) |-> (vlan_prio == 3'd0));
   assert_err_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && frame_err) |=> (fclass == FC_ERROR && !accept));
endmodule

// File: tb/tb_rxf_filter.sv
module tb_rxf_filter;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         hdr_valid;
   logic [47:0]  dest_addr;
   logic [15:0]  len_type, vlan_tci, byte_count;
   logic         frame_err;
   logic [191:0] ucast_addr;
   logic [11:0]  ucast_chan;
   logic [3:0]   ucast_valid;
   logic [7:0]   ucast_chan_en;
   logic [63:0]  tbl;
   logic [31:0]  hash_lo, hash_hi;
   logic         mcast_en, bcast_en, promisc_en, max_len_wr;
   logic [2:0]   mcast_chan, bcast_chan, promisc_chan;
   logic [15:0]  max_len_wdata;
   logic         out_valid, accept, filtered;
   logic [2:0]   chan, fclass, vlan_prio;

   assign hash_lo = tbl[31:0];
   assign hash_hi = tbl[63:32];

   always #4 clk = ~clk;

   rxf_filter dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .dest_addr(dest_addr),
      .len_type(len_type), .vlan_tci(vlan_tci), .byte_count(byte_count),
      .frame_err(frame_err), .ucast_addr(ucast_addr), .ucast_chan(ucast_chan),
      .ucast_valid(ucast_valid), .ucast_chan_en(ucast_chan_en),
      .hash_lo(hash_lo), .hash_hi(hash_hi), .mcast_en(mcast_en),
      .mcast_chan(mcast_chan), .bcast_en(bcast_en), .bcast_chan(bcast_chan),
      .promisc_en(promisc_en), .promisc_chan(promisc_chan),
      .max_len_wr(max_len_wr), .max_len_wdata(max_len_wdata),
      .out_valid(out_valid), .accept(accept), .chan(chan), .fclass(fclass),
      .vlan_prio(vlan_prio), .filtered(filtered));

   int n_cmp = 0;
   int n_bad = 0;
   int m_max = 1518;
   logic       e_v, e_a, e_f;
   logic [2:0] e_ch, e_cls, e_pr;

   localparam logic [47:0] E0 = 48'h0000_5634_1200;
   localparam logic [47:0] E1 = 48'hF0E0_D0C0_B0A0;
   localparam logic [47:0] E3 = 48'h0000_0000_0042;
   localparam logic [47:0] GRP = 48'h3412_8967_4523;

   function automatic int fold_idx(input logic [47:0] a);
      int h = 0;
      for (int b = 0; b < 48; b++) if (a[b]) h = h ^ (1 << (b % 6));
      return h;
   endfunction

   task automatic predict();
      bit ok = 0;
      int ch = 0;
      int cls;
      e_v = hdr_valid; e_a = 0; e_f = 0; e_ch = 0; e_cls = 0; e_pr = 0;
      if (hdr_valid) begin
         if (frame_err) cls = 5;
         else if (int'(byte_count) < 64) cls = 1;
         else if (int'(byte_count) > m_max) cls = 2;
         else if (len_type == 16'h8808) cls = 3;
         else if (len_type == 16'h8100) cls = 4;
         else cls = 0;
         if (dest_addr == {48{1'b1}}) begin
            if (bcast_en) begin ok = 1; ch = int'(bcast_chan); end
         end else if (dest_addr[0]) begin
            if (mcast_en && tbl[fold_idx(dest_addr)]) begin ok = 1; ch = int'(mcast_chan); end
         end else begin
            for (int k = 0; k < 4; k++) begin
               int c = int'(ucast_chan[k*3 +: 3]);
               if (!ok && ucast_valid[k] && ucast_addr[k*48 +: 48] == dest_addr
                   && ucast_chan_en[c]) begin ok = 1; ch = c; end
            end
         end
         if (!ok && promisc_en) begin ok = 1; ch = int'(promisc_chan); end
         e_f   = !ok;
         e_a   = ok && (cls == 0 || cls == 4);
         e_ch  = e_a ? 3'(ch) : 3'd0;
         e_cls = 3'(cls);
         e_pr  = (cls == 4) ? vlan_tci[15:13] : 3'd0;
      end
   endtask

   task automatic cycle(input string tag);
      predict();
      @(posedge clk);
      #1;
      n_cmp++;
      if ({out_valid, accept, chan, fclass, vlan_prio, filtered} !==
          {e_v, e_a, e_ch, e_cls, e_pr, e_f}) begin
         n_bad++;
         $display("FAIL %s: got v=%0b acc=%0b ch=%0d cls=%0d pr=%0d filt=%0b expected v=%0b acc=%0b ch=%0d cls=%0d pr=%0d filt=%0b",
                  tag, out_valid, accept, chan, fclass, vlan_prio, filtered,
                  e_v, e_a, e_ch, e_cls, e_pr, e_f);
      end
      if (max_len_wr) m_max = int'(max_len_wdata);
   endtask

   task automatic send(input logic [47:0] da, input logic [15:0] lt,
                       input logic [15:0] bc, input logic err, input string tag);
      dest_addr = da; len_type = lt; byte_count = bc; frame_err = err;
      hdr_valid = 1'b1;
      cycle(tag);
      hdr_valid = 1'b0;
      cycle({tag, " idle R1"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1: got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; hdr_valid = 0; dest_addr = '0; len_type = 16'h0800;
      vlan_tci = 16'h0; byte_count = 16'd100; frame_err = 0;
      ucast_addr = {E3, E1, E1, E0};
      ucast_chan = {3'd3, 3'd6, 3'd5, 3'd1};
      ucast_valid = 4'b0111; ucast_chan_en = 8'hFF; tbl = '0;
      mcast_en = 0; bcast_en = 0; promisc_en = 0;
      mcast_chan = 3'd2; bcast_chan = 3'd4; promisc_chan = 3'd7;
      max_len_wr = 0; max_len_wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if ({out_valid, accept, chan, fclass, vlan_prio, filtered} !== 12'd0) begin
         n_bad++;
         $display("FAIL R11 reset: got %0h expected 0",
                  {out_valid, accept, chan, fclass, vlan_prio, filtered});
      end
      rst_n = 1;
      cycle("R11 after reset");

      send(E0, 16'h0800, 16'd100, 0, "R4 entry0");
      send(E1, 16'h0800, 16'd100, 0, "R4 lowest index");
      ucast_chan_en = 8'hDF;
      send(E1, 16'h0800, 16'd100, 0, "R4 disabled channel");
      ucast_chan_en = 8'hFF;
      send(E3, 16'h0800, 16'd100, 0, "R4 invalid entry");

      promisc_en = 1;
      send(48'h0000_1111_2222, 16'h0800, 16'd100, 0, "R5 promisc");
      promisc_en = 0;
      send(48'h0000_1111_2222, 16'h0800, 16'd100, 0, "R5 filtered");

      mcast_en = 1;
      send(GRP, 16'h0800, 16'd100, 0, "R2 hash bit clear");
      tbl[fold_idx(GRP)] = 1'b1;
      send(GRP, 16'h0800, 16'd100, 0, "R2 hash bit set");
      mcast_en = 0;
      send(GRP, 16'h0800, 16'd100, 0, "R2 mcast disabled");

      bcast_en = 1;
      send({48{1'b1}}, 16'h0800, 16'd100, 0, "R3 broadcast");
      bcast_en = 0; mcast_en = 1; tbl = '1;
      send({48{1'b1}}, 16'h0800, 16'd100, 0, "R3 broadcast off");
      tbl = '0;

      send(E0, 16'h0800, 16'd63, 0, "R6 undersized");
      send(E0, 16'h0800, 16'd64, 0, "R6 minimum");
      send(E0, 16'h0800, 16'd1518, 0, "R7 reset maximum");
      send(E0, 16'h0800, 16'd1519, 0, "R7 reset maximum plus one");
      max_len_wr = 1; max_len_wdata = 16'd100;
      cycle("R7 load");
      max_len_wr = 0;
      send(E0, 16'h0800, 16'd100, 0, "R7 loaded maximum");
      send(E0, 16'h0800, 16'd101, 0, "R6 oversized");

      send(E0, 16'h8808, 16'd64, 0, "R8 pause");
      vlan_tci = 16'hA123;
      send(E0, 16'h8100, 16'd80, 0, "R9 vlan");
      send(E0, 16'h8808, 16'd80, 0, "R9 prio zero");
      send(E0, 16'h8100, 16'd20, 1, "R10 errored");

      for (int i = 0; i < 400; i++) begin
         int sel = $urandom_range(0, 5);
         logic [47:0] da;
         case (sel)
            0: da = E0;
            1: da = E1;
            2: da = {48{1'b1}};
            3: da = {$urandom(), $urandom()} | 48'h1;
            default: da = {$urandom(), $urandom()} & ~48'h1;
         endcase
         if (i % 37 == 0) begin
            tbl = {$urandom(), $urandom()};
            ucast_chan_en = 8'($urandom());
            promisc_en = 1'($urandom()); mcast_en = 1'($urandom());
            bcast_en = 1'($urandom());
            mcast_chan = 3'($urandom()); promisc_chan = 3'($urandom());
         end
         vlan_tci = 16'($urandom());
         send(da, ($urandom_range(0, 3) == 0) ? 16'h8100 :
                  ($urandom_range(0, 5) == 0) ? 16'h8808 : 16'h0800,
              16'($urandom_range(40, 130)), ($urandom_range(0, 9) == 0),
              "random R2 R4 R5 R6");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule